// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder into a signed position count. Both phases are brought into the clock domain through a two-stage synchronizer. Every clock, the last evaluated phase pair and the current one form a 4-bit index. A fixed rule maps that index to a step of -2, -1, 0, +1 or +2, and the step is added to the count. When a sample misses an intermediate state, so that both phases flip at once, the block does not drop the move. It counts it as two steps, taking the direction that applies when the A phase moved.

After reset the block waits for a settling time given in microseconds. This lets slow external RC filtering charge. It then captures the phase pair that is present as the reference pair and raises `ready`. The reference pair is never assumed to be 00.

The host sees the count at all times on `pos_out`. It can load any value through the write port. A read-and-clear strobe copies the count to `clr_value` and restarts the count in the same clock edge, so no step is lost.

Top module: `quad_pos_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pos_out` is 0, `ready` is 0 and `clr_valid` is 0.
- R2: A change on `ch_a`/`ch_b` that is stable before rising edge k is first reflected in `pos_out` after rising edge k+2. After edge k+1 the old count is still shown.
- R3: The lookup index is {new B, new A, old B, old A}, bit 3 down to bit 0. Index 1, 7, 8 and 14 add one. Index 2, 4, 11 and 13 subtract one.
- R4: Index 3 and 12 add two. Index 6 and 9 subtract two. Neither case is dropped or flagged.
- R5: Index 0, 5, 10 and 15 leave the count unchanged.
- R6: After each evaluation the new pair becomes the old pair, so a held input never adds to the count again.
- R7: `ready` stays low for `SETTLE_US` microseconds of `CLK_HZ` clock after reset. It then rises and stays high. The reference pair is taken from the synchronized inputs at that moment. Input motion before that point never changes the count.
- R8: `wr_en` loads `wr_pos` into the count at the next edge. It takes precedence over a step and over a read-and-clear in the same cycle.
- R9: On a cycle with `clr_strobe` high, the next edge puts the count from before that edge on `clr_value` and raises `clr_valid` for exactly one cycle. The count becomes the step evaluated in that same cycle, which is 0 when there is no motion.
- R10: The count wraps in two's complement. +1 from 0x7FFFFFFF gives 0x80000000, and -1 from 0x80000000 gives 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_a | input | 1 | Phase A, asynchronous |
| ch_b | input | 1 | Phase B, asynchronous |
| wr_en | input | 1 | Load strobe for the count |
| wr_pos | input | POS_W | Value to load |
| clr_strobe | input | 1 | Read-and-clear request |
| pos_out | output | POS_W | Current signed count |
| clr_value | output | POS_W | Count captured by the last read-and-clear |
| clr_valid | output | 1 | One-cycle pulse when `clr_value` is updated |
| ready | output | 1 | High once the reference pair is captured |

## Verification
The decoder is driven through a full forward quadrature cycle and a full reverse cycle. These separate the +1 indices from the -1 indices and show that the direction depends on phase order, not on level. Diagonal jumps are then applied in both rotations and from both phase polarities. They show that a skipped state gives exactly two counts and that its sign follows the assumed A edge. A held pair shows that a stale pair is never re-counted. Directed cases place a step in the same cycle as a read-and-clear or as a write. They also run the count across both wrap boundaries, and they move the inputs during settling from a non-zero pair, which tells a captured reference apart from one assumed to be zero.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int STEP_W = 3;
  typedef logic signed [STEP_W-1:0] step_t;

  // index = {new_b, new_a, old_b, old_a}
  function automatic step_t step_of(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd7, 4'd8, 4'd14:  return 3'sd1;
      4'd2, 4'd4, 4'd11, 4'd13: return -3'sd1;
      4'd3, 4'd12:              return 3'sd2;
      4'd6, 4'd9:               return -3'sd2;
      default:                  return 3'sd0;
    endcase
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_settle.sv
module qdec_settle #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_US = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic arm_o,
  output logic ready_o
);
  localparam int RAW_N  = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int WAIT_N = (RAW_N < 1) ? 1 : RAW_N;
  localparam int CNT_W  = $clog2(WAIT_N + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit   = !ready_o && (cnt_q == LAST);
  assign arm_o = hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (hit) ready_o <= 1'b1;
    end
  end

  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (cnt_q <= LAST));
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm_i,
  input  logic       en_i,
  input  logic [1:0] pair_i,   // {b, a}
  output step_t      step_o
);
  logic [1:0] old_q;

  always_ff @(posedge clk) begin
    if (rst)                 old_q <= 2'b00;
    else if (arm_i || en_i)  old_q <= pair_i;
  end

  assign step_o = en_i ? step_of({pair_i, old_q}) : step_t'(0);

  assert_old_follows_R6: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (old_q == $past(pair_i)));
  assert_capture_ref_R7: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (old_q == $past(pair_i)));
endmodule

// File: rtl/qdec_accum.sv
module qdec_accum
  import qdec_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  step_t            step_i,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_val_i,
  input  logic             clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] snap_o,
  output logic             snap_vld_o
);
  localparam int EXT_W = POS_W - STEP_W;
  logic [POS_W-1:0] step_ext;

  assign step_ext = {{EXT_W{step_i[STEP_W-1]}}, step_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o      <= '0;
      snap_o     <= '0;
      snap_vld_o <= 1'b0;
    end else begin
      snap_vld_o <= clr_i;
      if (clr_i) snap_o <= pos_o;
      if (wr_en_i)    pos_o <= wr_val_i;
      else if (clr_i) pos_o <= step_ext;
      else            pos_o <= pos_o + step_ext;
    end
  end

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (pos_o == $past(wr_val_i)));
  assert_clear_keeps_step_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !wr_en_i) |=> (pos_o == $past(step_ext)));
  assert_snapshot_R9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (snap_vld_o && snap_o == $past(pos_o)));
  assert_accumulate_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !wr_en_i) |=> (pos_o == $past(pos_o) + $past(step_ext)));
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qdec_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_HZ      = 125_000_000,
  parameter int SETTLE_US   = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch_a,
  input  logic             ch_b,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             clr_strobe,
  output logic [POS_W-1:0] pos_out,
  output logic [POS_W-1:0] clr_value,
  output logic             clr_valid,
  output logic             ready
);
  logic [1:0] pair_s;
  logic       arm;
  step_t      step;

  qdec_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({ch_b, ch_a}), .q_o(pair_s));

  qdec_settle #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u_settle (
    .clk(clk), .rst(rst), .arm_o(arm), .ready_o(ready));

  qdec_step u_step (
    .clk(clk), .rst(rst), .arm_i(arm), .en_i(ready),
    .pair_i(pair_s), .step_o(step));

  qdec_accum #(.POS_W(POS_W)) u_accum (
    .clk(clk), .rst(rst), .step_i(step), .wr_en_i(wr_en),
    .wr_val_i(wr_pos), .clr_i(clr_strobe), .pos_o(pos_out),
    .snap_o(clr_value), .snap_vld_o(clr_valid));

  assert_idle_before_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !wr_en && !clr_strobe) |=> $stable(pos_out));
endmodule

// File: tb/test_quad_pos_decoder.sv
module test_quad_pos_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch_a = 1'b1, ch_b = 1'b0;
  logic        wr_en = 1'b0, clr_strobe = 1'b0;
  logic [31:0] wr_pos = '0;
  logic [31:0] pos_out, clr_value;
  logic        clr_valid, ready;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  quad_pos_decoder #(.POS_W(32), .SYNC_STAGES(2), .CLK_HZ(125_000_000),
                     .SETTLE_US(1)) i_quad_pos_decoder (
    .clk(clk), .rst(rst), .ch_a(ch_a), .ch_b(ch_b), .wr_en(wr_en),
    .wr_pos(wr_pos), .clr_strobe(clr_strobe), .pos_out(pos_out),
    .clr_value(clr_value), .clr_valid(clr_valid), .ready(ready));

  // new pair {b,a} and count expected after it, starting from pair 01, count 0
  localparam int NV = 14;
  localparam logic [1:0] VPAIR [NV] = '{2'b00, 2'b10, 2'b11, 2'b01,
                                        2'b11, 2'b10, 2'b00, 2'b01,
                                        2'b10, 2'b01, 2'b00, 2'b11,
                                        2'b00, 2'b00};
  localparam int VPOS [NV] = '{1, 2, 3, 4, 3, 2, 1, 0, -2, -4, -3, -1, 1, 1};
  localparam string VREQ [NV] = '{"R3", "R3", "R3", "R3", "R3", "R3", "R3",
                                  "R3", "R4", "R4", "R3", "R4", "R4", "R5"};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_pair(input logic [1:0] p);
    @(negedge clk);
    ch_b = p[1];
    ch_a = p[0];
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1", pos_out, 0);
    check("R1", {31'd0, ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", pos_out, 0);
    check("R1", {31'd0, clr_valid}, 0);

    // R7: movement during settling must not count; final pair 01
    ch_a = 1'b0; repeat (10) @(negedge clk);
    ch_b = 1'b1; repeat (10) @(negedge clk);
    ch_b = 1'b0; ch_a = 1'b1; repeat (10) @(negedge clk);
    check("R7", {31'd0, ready}, 0);
    check("R7", pos_out, 0);
    repeat (150) @(negedge clk);
    check("R7", {31'd0, ready}, 1);
    check("R7", pos_out, 0);  // reference 01 captured, not 00

    for (int i = 0; i < NV; i++) begin
      set_pair(VPAIR[i]);
      check(VREQ[i], pos_out, 32'(VPOS[i]));
    end
    repeat (5) @(negedge clk);
    check("R6", pos_out, 1);

    // R8 write, R10 wrap both ways; current pair 00
    @(negedge clk); wr_en = 1'b1; wr_pos = 32'h7FFF_FFFF;
    @(negedge clk); wr_en = 1'b0;
    check("R8", pos_out, 32'h7FFF_FFFF);
    set_pair(2'b10);
    check("R10", pos_out, 32'h8000_0000);
    set_pair(2'b00);
    check("R10", pos_out, 32'h7FFF_FFFF);

    // R9 plain read-and-clear
    @(negedge clk); clr_strobe = 1'b1;
    @(negedge clk); clr_strobe = 1'b0;
    check("R9", clr_value, 32'h7FFF_FFFF);
    check("R9", {31'd0, clr_valid}, 1);
    check("R9", pos_out, 0);
    @(negedge clk);
    check("R9", {31'd0, clr_valid}, 0);

    // R9 clear in the cycle the step lands; R2 latency
    @(negedge clk); wr_en = 1'b1; wr_pos = 32'd5;
    @(negedge clk); wr_en = 1'b0;
    ch_b = 1'b1;                   // 00 -> 10 : +1
    @(negedge clk);
    check("R2", pos_out, 5);
    @(negedge clk);
    check("R2", pos_out, 5);
    clr_strobe = 1'b1;
    @(negedge clk); clr_strobe = 1'b0;
    check("R9", clr_value, 5);
    check("R9", pos_out, 1);

    // R8 write in the cycle a step lands
    @(negedge clk); ch_a = 1'b1;   // 10 -> 11 : +1
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_pos = 32'd100;
    @(negedge clk); wr_en = 1'b0;
    check("R8", pos_out, 100);
    repeat (3) @(negedge clk);
    check("R6", pos_out, 100);

    // R8 write beats clear in the same cycle
    @(negedge clk); wr_en = 1'b1; wr_pos = 32'd42; clr_strobe = 1'b1;
    @(negedge clk); wr_en = 1'b0; clr_strobe = 1'b0;
    check("R8", pos_out, 42);
    check("R9", clr_value, 100);

    finish_run();
  end
endmodule